// File: doc/BRIEF.md
# Banked Virtual-Queue Configuration Registers with Notify Decode

This block keeps the setup of a small set of virtual queues on a memory-mapped register front end. Software writes a queue index into a select register, then reads the queue's size limit and writes its element count, its used-ring alignment and its guest page frame number. All of these accesses go to whichever queue the select register names. A page frame number of zero means the queue is idle. Any non-zero value marks the queue live and places its descriptor table at that guest page.

For every queue the block drives an active flag and the byte base address of the queue. The base address is the page frame number shifted left by log2 of the guest page size, which arrives on an input from the front end. A write of a queue index to the notify offset is turned into a single-cycle pulse that carries the index. The pulse is produced only when the index names a queue that exists and is active. A synchronous device-reset strobe from the front end returns all queue state and the selection to zero.

Top module: `vq_cfg_bank`

## Requirements
- R1: After `rst_n` is released, and in the cycle after `dev_reset` is sampled high, every queue's count, alignment and page number read as 0, the selection is 0, all `q_active` bits are 0 and `notify_valid` is 0.
- R2: The register offsets are: select 0x030, size limit 0x034 (read only), count 0x038, alignment 0x03C, page number 0x040, notify 0x050. The count, alignment and page number read back the values held for the queue named by the last write to 0x030. Reading 0x030 returns the selection. Unlisted offsets read 0.
- R3: Offset 0x034 reads MAX_BASE >> i for a selected queue i < NQ, and 0 when the selection is NQ or above.
- R4: A write to 0x038 stores min(written value, size limit of the selected queue).
- R5: A write to 0x03C is stored only when the value is a non-zero power of two. Any other value leaves the stored alignment unchanged.
- R6: A write to 0x040 stores the full 32-bit value. `q_active[i]` is 1 exactly when queue i holds a non-zero page number.
- R7: Count, alignment and page-number writes made while the selection is NQ or above change no queue.
- R8: `q_base` slice i equals (page number of queue i) << log2(`pg_size`), truncated to AW bits. `pg_size` is a power of two.
- R9: A write of value n to 0x050 raises `notify_valid` for exactly the next cycle with `notify_idx` = n, but only when n < NQ and queue n is active. Otherwise no pulse follows.
- R10: When `dev_reset` is high in the same cycle as a register write, the reset takes effect and the write is dropped. A notify write in that cycle produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_reset | input | 1 | Synchronous device-reset strobe from the front end |
| pg_size | input | 32 | Guest page size in bytes (power of two) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| q_active | output | NQ | Per-queue active flag |
| q_base | output | NQ*AW | Per-queue base byte address, queue 0 in the low slice |
| notify_valid | output | 1 | One-cycle notify pulse |
| notify_idx | output | IW | Queue index carried with the notify pulse |

## Verification
Two events can land on the same clock edge: the device-reset strobe and a register write. The write may be a count update or a notify of a live queue. The bench drives both in a single cycle. It then checks through the read port that the count is still zero, and at the output that no notify pulse follows, so the reset is judged to win. The bench also sweeps the notify index across every active-queue pattern, including out-of-range indices. This tests the pulse decision that uses the page numbers written in earlier cycles.

// File: rtl/vqc_pkg.sv
package vqc_pkg;

  localparam logic [11:0] OFS_SEL    = 12'h030;
  localparam logic [11:0] OFS_LIMIT  = 12'h034;
  localparam logic [11:0] OFS_COUNT  = 12'h038;
  localparam logic [11:0] OFS_ALIGN  = 12'h03C;
  localparam logic [11:0] OFS_PAGE   = 12'h040;
  localparam logic [11:0] OFS_NOTIFY = 12'h050;

  typedef struct packed {
    logic [31:0] count;
    logic [31:0] align;
    logic [31:0] page;
  } vq_slot_t;

  // index of the highest set bit; 0 for an input of 0
  function automatic logic [4:0] pg_log2(input logic [31:0] v);
    logic [4:0] r;
    r = 5'd0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  function automatic logic is_pow2(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

  function automatic logic [31:0] clamp_count(input logic [31:0] v, input logic [31:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [63:0] page_base(input logic [31:0] page, input logic [4:0] sh);
    return {32'd0, page} << sh;
  endfunction

endpackage

// File: rtl/vqc_decode.sv
module vqc_decode
  import vqc_pkg::*;
#(
  parameter int unsigned NQ = 4
) (
  input  logic        wr_en,
  input  logic        dev_reset,
  input  logic [11:0] wr_addr,
  input  logic [31:0] sel_q,
  output logic        sel_ok,
  output logic        hit_sel,
  output logic        hit_count,
  output logic        hit_align,
  output logic        hit_page,
  output logic        hit_notify
);

  logic wr_live;

  assign sel_ok  = (sel_q < 32'(NQ));
  assign wr_live = wr_en && !dev_reset;

  always_comb begin
    hit_sel    = 1'b0;
    hit_count  = 1'b0;
    hit_align  = 1'b0;
    hit_page   = 1'b0;
    hit_notify = 1'b0;
    if (wr_live) begin
      case (wr_addr)
        OFS_SEL:    hit_sel    = 1'b1;
        OFS_COUNT:  hit_count  = sel_ok;
        OFS_ALIGN:  hit_align  = sel_ok;
        OFS_PAGE:   hit_page   = sel_ok;
        OFS_NOTIFY: hit_notify = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vqc_slot.sv
module vqc_slot
  import vqc_pkg::*;
#(
  parameter int unsigned IDX      = 0,
  parameter int unsigned MAX_BASE = 256,
  parameter int unsigned AW       = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we_count,
  input  logic          we_align,
  input  logic          we_page,
  input  logic [31:0]   wdata,
  input  logic [4:0]    pg_shift,
  output vq_slot_t      slot,
  output logic [31:0]   limit,
  output logic          active,
  output logic [AW-1:0] base
);

  localparam logic [31:0] QLIMIT = 32'(MAX_BASE >> IDX);

  vq_slot_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (clr) begin
      st <= '0;
    end else begin
      if (we_count)                   st.count <= clamp_count(wdata, QLIMIT);
      if (we_align && is_pow2(wdata)) st.align <= wdata;
      if (we_page)                    st.page  <= wdata;
    end
  end

  assign slot   = st;
  assign limit  = QLIMIT;
  assign active = (st.page != 32'd0);
  assign base   = AW'(page_base(st.page, pg_shift));

endmodule

// File: rtl/vqc_notify.sv
module vqc_notify #(
  parameter int unsigned NQ = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hit_notify,
  input  logic [31:0]   wdata,
  input  logic [NQ-1:0] active,
  output logic          pulse,
  output logic [IW-1:0] idx
);

  logic in_range;
  logic fire;

  assign in_range = (wdata < 32'(NQ));
  assign fire     = hit_notify && in_range && active[IW'(wdata)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      idx   <= '0;
    end else if (clr) begin
      pulse <= 1'b0;
    end else begin
      pulse <= fire;
      if (fire) idx <= IW'(wdata);
    end
  end

endmodule

// File: rtl/vq_cfg_bank.sv
module vq_cfg_bank
  import vqc_pkg::*;
#(
  parameter int unsigned NQ       = 4,
  parameter int unsigned MAX_BASE = 256,
  parameter int unsigned AW       = 48,
  localparam int unsigned IW      = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_reset,
  input  logic [31:0]      pg_size,
  input  logic             wr_en,
  input  logic [11:0]      wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [11:0]      rd_addr,
  output logic [31:0]      rd_data,
  output logic [NQ-1:0]    q_active,
  output logic [NQ*AW-1:0] q_base,
  output logic             notify_valid,
  output logic [IW-1:0]    notify_idx
);

  logic [31:0] sel_q;
  logic        sel_ok;
  logic        hit_sel, hit_count, hit_align, hit_page, hit_notify;
  logic [4:0]  pg_shift;

  logic [NQ-1:0][31:0] slot_count;
  logic [NQ-1:0][31:0] slot_align;
  logic [NQ-1:0][31:0] slot_page;
  logic [NQ-1:0][31:0] slot_limit;

  assign pg_shift = pg_log2(pg_size);

  vqc_decode #(.NQ(NQ)) u_dec (
    .wr_en      (wr_en),
    .dev_reset  (dev_reset),
    .wr_addr    (wr_addr),
    .sel_q      (sel_q),
    .sel_ok     (sel_ok),
    .hit_sel    (hit_sel),
    .hit_count  (hit_count),
    .hit_align  (hit_align),
    .hit_page   (hit_page),
    .hit_notify (hit_notify)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= 32'd0;
    else if (dev_reset) sel_q <= 32'd0;
    else if (hit_sel)   sel_q <= wr_data;
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    vq_slot_t slot_w;
    logic     mine;

    assign mine = (sel_q == 32'(g));

    vqc_slot #(.IDX(g), .MAX_BASE(MAX_BASE), .AW(AW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (dev_reset),
      .we_count (hit_count && mine),
      .we_align (hit_align && mine),
      .we_page  (hit_page && mine),
      .wdata    (wr_data),
      .pg_shift (pg_shift),
      .slot     (slot_w),
      .limit    (slot_limit[g]),
      .active   (q_active[g]),
      .base     (q_base[g*AW +: AW])
    );

    assign slot_count[g] = slot_w.count;
    assign slot_align[g] = slot_w.align;
    assign slot_page[g]  = slot_w.page;
  end

  vqc_notify #(.NQ(NQ), .IW(IW)) u_ntf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (dev_reset),
    .hit_notify (hit_notify),
    .wdata      (wr_data),
    .active     (q_active),
    .pulse      (notify_valid),
    .idx        (notify_idx)
  );

  // read mux: banked fields follow the selection
  always_comb begin
    logic [31:0] lim, cnt, aln, pg;
    lim = 32'd0;
    cnt = 32'd0;
    aln = 32'd0;
    pg  = 32'd0;
    for (int i = 0; i < NQ; i++) begin
      if (sel_q == 32'(i)) begin
        lim = slot_limit[i];
        cnt = slot_count[i];
        aln = slot_align[i];
        pg  = slot_page[i];
      end
    end
    case (rd_addr)
      OFS_SEL:   rd_data = sel_q;
      OFS_LIMIT: rd_data = lim;
      OFS_COUNT: rd_data = cnt;
      OFS_ALIGN: rd_data = aln;
      OFS_PAGE:  rd_data = pg;
      default:   rd_data = 32'd0;
    endcase
  end

endmodule

// File: rtl/vqc_chk.sv
module vqc_chk
  import vqc_pkg::*;
#(
  parameter int unsigned NQ = 4,
  parameter int unsigned AW = 48,
  parameter int unsigned IW = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dev_reset,
  input logic                wr_en,
  input logic [11:0]         wr_addr,
  input logic                sel_ok,
  input logic [31:0]         sel_q,
  input logic [4:0]          pg_shift,
  input logic [NQ-1:0]       q_active,
  input logic [NQ*AW-1:0]    q_base,
  input logic                notify_valid,
  input logic [IW-1:0]       notify_idx,
  input logic [NQ-1:0][31:0] slot_count,
  input logic [NQ-1:0][31:0] slot_limit
);

  // R9
  notify_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(wr_en && wr_addr == OFS_NOTIFY && !dev_reset));

  // R9
  notify_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> (32'(notify_idx) < 32'(NQ)) && q_active[notify_idx]);

  // R10
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> (q_active == '0) && !notify_valid && (sel_q == 32'd0));

  // R7
  oob_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dev_reset && !sel_ok &&
     (wr_addr == OFS_COUNT || wr_addr == OFS_ALIGN || wr_addr == OFS_PAGE))
    |=> $stable(q_active));

  for (genvar g = 0; g < NQ; g++) begin : g_c
    // R4
    count_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_count[g] <= slot_limit[g]);

    // R8
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((64'(q_base[g*AW +: AW]) & ((64'd1 << pg_shift) - 64'd1)) == 64'd0));
  end

endmodule

bind vq_cfg_bank vqc_chk #(.NQ(NQ), .AW(AW), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dev_reset    (dev_reset),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .sel_ok       (sel_ok),
  .sel_q        (sel_q),
  .pg_shift     (pg_shift),
  .q_active     (q_active),
  .q_base       (q_base),
  .notify_valid (notify_valid),
  .notify_idx   (notify_idx),
  .slot_count   (slot_count),
  .slot_limit   (slot_limit)
);

// File: tb/vq_cfg_bank_test.sv
module vq_cfg_bank_test;

  localparam int NQ = 4;
  localparam int MB = 256;
  localparam int AW = 48;
  localparam int IW = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dev_reset = 1'b0;
  logic [31:0]      pg_size = 32'd4096;
  logic             wr_en = 1'b0;
  logic [11:0]      wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic [11:0]      rd_addr = '0;
  logic [31:0]      rd_data;
  logic [NQ-1:0]    q_active;
  logic [NQ*AW-1:0] q_base;
  logic             notify_valid;
  logic [IW-1:0]    notify_idx;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] m_cnt [NQ];
  logic [31:0] m_aln [NQ];
  logic [31:0] m_pg  [NQ];

  always #10 clk = ~clk;

  vq_cfg_bank #(.NQ(NQ), .MAX_BASE(MB), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .pg_size(pg_size),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .q_active(q_active), .q_base(q_base),
    .notify_valid(notify_valid), .notify_idx(notify_idx)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic rs);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; dev_reset = rs;
    @(negedge clk);
    wr_en = 1'b0; dev_reset = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [31:0] lim_of(input int q);
    return (q < NQ) ? 32'(MB >> q) : 32'd0;
  endfunction

  task automatic check_queue(input string tag, input int q);
    logic [31:0] d;
    wr(12'h030, 32'(q), 1'b0);
    rd(12'h038, d); chk({tag, " count"}, 64'(d), 64'(m_cnt[q]));
    rd(12'h03C, d); chk({tag, " align"}, 64'(d), 64'(m_aln[q]));
    rd(12'h040, d); chk({tag, " page"},  64'(d), 64'(m_pg[q]));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int q = 0; q < NQ; q++) begin m_cnt[q] = 0; m_aln[q] = 0; m_pg[q] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 active", 64'(q_active), 64'd0);
    chk("R1 notify", 64'(notify_valid), 64'd0);
    rd(12'h030, d); chk("R1 sel", 64'(d), 64'd0);
    for (int q = 0; q < NQ; q++) check_queue("R1", q);
    rd(12'h010, d); chk("R2 unmapped", 64'(d), 64'd0);

    // R3 size limit per selection
    for (int s = 0; s < 8; s++) begin
      wr(12'h030, 32'(s), 1'b0);
      rd(12'h030, d); chk("R2 sel readback", 64'(d), 64'(s));
      rd(12'h034, d); chk("R3 limit", 64'(d), 64'(lim_of(s)));
    end

    // R4 clamp sweep
    for (int q = 0; q < NQ; q++) begin
      logic [31:0] vals [6];
      vals = '{32'd0, 32'd1, lim_of(q) - 1, lim_of(q), lim_of(q) + 1, 32'hFFFF_FFFF};
      wr(12'h030, 32'(q), 1'b0);
      foreach (vals[k]) begin
        wr(12'h038, vals[k], 1'b0);
        m_cnt[q] = (vals[k] > lim_of(q)) ? lim_of(q) : vals[k];
        rd(12'h038, d); chk("R4 clamp", 64'(d), 64'(m_cnt[q]));
      end
      wr(12'h038, 32'(q + 5), 1'b0);
      m_cnt[q] = 32'(q + 5);
    end
    // R2 banking: every queue keeps its own count
    for (int q = 0; q < NQ; q++) check_queue("R2", q);

    // R5 alignment sweep
    for (int q = 0; q < NQ; q++) begin
      wr(12'h030, 32'(q), 1'b0);
      for (int k = 0; k < 32; k++) begin
        wr(12'h03C, 32'd1 << k, 1'b0);
        rd(12'h03C, d); chk("R5 pow2", 64'(d), 64'(32'd1 << k));
      end
      m_aln[q] = 32'd1 << ((q * 3) % 32);
      wr(12'h03C, m_aln[q], 1'b0);
      for (int k = 0; k < 5; k++) begin
        logic [31:0] bad [5];
        bad = '{32'd0, 32'd3, 32'd6, 32'hFFFF_FFFF, 32'h8000_0001};
        wr(12'h03C, bad[k], 1'b0);
        rd(12'h03C, d); chk("R5 ignored", 64'(d), 64'(m_aln[q]));
      end
    end

    // R6 / R8 page number and base over page sizes
    for (int q = 0; q < NQ; q++) begin
      m_pg[q] = (q == 3) ? 32'hFFFF_FFFF : 32'h0001_2340 + 32'(q * 17);
      wr(12'h030, 32'(q), 1'b0);
      wr(12'h040, m_pg[q], 1'b0);
    end
    for (int k = 0; k <= 16; k++) begin
      pg_size = 32'd1 << k;
      #1;
      for (int q = 0; q < NQ; q++) begin
        logic [63:0] e;
        e = ({32'd0, m_pg[q]} << k) & ((64'd1 << AW) - 1);
        chk("R8 base", 64'(q_base[q*AW +: AW]), e);
      end
    end
    chk("R6 active all", 64'(q_active), 64'hF);
    for (int q = 0; q < NQ; q++) check_queue("R6", q);

    // R7 out-of-range selection writes dropped
    wr(12'h030, 32'd9, 1'b0);
    wr(12'h038, 32'd2, 1'b0);
    wr(12'h03C, 32'd8, 1'b0);
    wr(12'h040, 32'd0, 1'b0);
    chk("R7 active", 64'(q_active), 64'hF);
    rd(12'h034, d); chk("R7 limit", 64'(d), 64'd0);
    for (int q = 0; q < NQ; q++) check_queue("R7", q);

    // R9 notify across activity patterns
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < NQ; q++) begin
        m_pg[q] = p[q] ? 32'(q + 1) : 32'd0;
        wr(12'h030, 32'(q), 1'b0);
        wr(12'h040, m_pg[q], 1'b0);
      end
      chk("R6 active pattern", 64'(q_active), 64'(p));
      for (int n = 0; n < 6; n++) begin
        logic ev;
        ev = (n < NQ) && p[n];
        wr(12'h050, 32'(n), 1'b0);
        chk("R9 pulse", 64'(notify_valid), 64'(ev));
        if (ev) chk("R9 index", 64'(notify_idx), 64'(n));
        @(negedge clk);
        chk("R9 one cycle", 64'(notify_valid), 64'd0);
      end
    end
    wr(12'h050, 32'h1_0000_001 & 32'hFFFF_FFFF, 1'b0);
    chk("R9 high bits out of range", 64'(notify_valid), 64'd0);

    // R10 reset coinciding with writes
    wr(12'h030, 32'd0, 1'b0);
    wr(12'h040, 32'd7, 1'b0);
    wr(12'h038, 32'd3, 1'b0);
    wr(12'h038, 32'd9, 1'b1);
    for (int q = 0; q < NQ; q++) begin m_cnt[q] = 0; m_aln[q] = 0; m_pg[q] = 0; end
    check_queue("R10 count write", 0);
    wr(12'h040, 32'd7, 1'b0);
    wr(12'h050, 32'd0, 1'b1);
    chk("R10 notify dropped", 64'(notify_valid), 64'd0);
    chk("R10 active cleared", 64'(q_active), 64'd0);

    // R1 device reset alone after full setup
    for (int q = 0; q < NQ; q++) begin
      wr(12'h030, 32'(q), 1'b0);
      wr(12'h038, 32'd4, 1'b0);
      wr(12'h03C, 32'd16, 1'b0);
      wr(12'h040, 32'd5, 1'b0);
    end
    chk("R6 active set", 64'(q_active), 64'hF);
    @(negedge clk); dev_reset = 1'b1;
    @(negedge clk); dev_reset = 1'b0;
    chk("R1 devreset active", 64'(q_active), 64'd0);
    rd(12'h030, d); chk("R1 devreset sel", 64'(d), 64'd0);
    rd(12'h034, d); chk("R1 devreset limit q0", 64'(d), 64'(MB));
    for (int q = 0; q < NQ; q++) check_queue("R1 devreset", q);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule